// File: doc/BRIEF.md
# Hex Keypad Scanner with Frame-Timed Debounce

This block finds which key of a 16-key hexadecimal keypad is pressed. The keypad is reached through a 4-bit select value that the block drives and a single sense line that reads back high when the selected key is down. After a one-cycle request, the block steps the select value downward, modulo 16, until the sense line reports a press. It then latches that code.

Debounce is timed in display frames, not clock cycles. A small down-counter is stepped by a frame tick, and the block reports the key only after the key has been pressed, released, and the line has settled twice. A tone output is high whenever this frame timer is nonzero, so it can drive a key-click beeper.

After reporting, the block waits for the next request before it scans again.

Top module: `hexpad_scanner`

## Requirements
- R1: After synchronous reset, `selOut` is 0, `keyCode` is 0, `keyValid` is 0 and `toneOn` is 0.
- R2: With no request since reset or since the last report, the block does not scan: `selOut` stays unchanged and a held key produces neither a tone nor a report.
- R3: While scanning, `selOut` steps down by one, modulo 16 (0 is followed by 15), and holds each value for `SETTLE_CYCLES` clock cycles. Scanning begins at the value `selOut` already holds.
- R4: `senseIn` passes through a two-flop synchronizer. It is sampled in the last cycle of each select slot. If it is high, scanning stops, `selOut` keeps the found code, and `keyCode` takes that same 4-bit code.
- R5: On detection, the frame timer is loaded with `DEBOUNCE_FRAMES` (default 4). The block waits until the timer reaches zero.
- R6: After that first wait, the timer is reloaded with `DEBOUNCE_FRAMES` on every cycle the synchronized key stays pressed. No report is made while the key is held, however many frame ticks occur.
- R7: After release, `keyValid` rises only once the timer has run down to zero again. That takes `DEBOUNCE_FRAMES` frame ticks after the release.
- R8: The frame timer decrements by one per `frameTick` while it is nonzero. Without a tick it holds its value. A tick at zero has no effect.
- R9: `toneOn` is high exactly while the frame timer is nonzero.
- R10: `keyValid` is a single-cycle pulse. `keyCode` holds the reported code afterwards, and only a new `scanReq` starts another scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scanReq | input | 1 | One-cycle request to start a scan while idle |
| frameTick | input | 1 | One-cycle pulse per video frame, steps the debounce timer |
| senseIn | input | 1 | Asynchronous key-sense line, high when the selected key is pressed |
| selOut | output | CODE_W (4) | Key select value driven to the keypad latch |
| keyCode | output | CODE_W (4) | Code of the last detected key |
| keyValid | output | 1 | One-cycle strobe announcing a debounced key |
| toneOn | output | 1 | High while the debounce timer is running |

## Verification
The bench builds the block with its default parameters: 4 cycles per select slot and 4 frames of debounce. With these values, a full sweep of the keypad takes 64 cycles, and each debounce phase can be stepped tick by tick. The bench supplies the frame ticks itself, so it can:
- place the boundary tick, after which the report must appear, and the tick before it, after which it must not;
- hold a key across many ticks to show the reload.

The stimulus covers a key that matches the current select value in the first slot, the same key twice in a row, a scan that wraps from 0 to 15, and a held key with no request.

// File: rtl/hexpad_pkg.sv
package hexpad_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic scanStart;  // restart the slot counter, keep select value
    logic stepSel;    // move select one code down, restart slot counter
    logic latchCode;  // capture select value as the key code
    logic loadTimer;  // reload the frame timer with the debounce length
  } dpCmd_t;

  // Status from datapath to control
  typedef struct packed {
    logic slotDone;   // last cycle of the current select slot
    logic keyDown;    // synchronized sense line
    logic timerIdle;  // frame timer at zero
  } dpStat_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_PRESS_WAIT,
    ST_HOLD_WAIT,
    ST_QUIET_WAIT,
    ST_REPORT
  } scanState_t;

endpackage

// File: rtl/hexpad_dp.sv
module hexpad_dp
  import hexpad_pkg::*;
#(
  parameter int CODE_W          = 4,
  parameter int SETTLE_CYCLES   = 4,
  parameter int DEBOUNCE_FRAMES = 4,
  parameter int SYNC_STAGES     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frameTick,
  input  logic              senseIn,
  input  dpCmd_t            cmd,
  output dpStat_t           stat,
  output logic [CODE_W-1:0] selOut,
  output logic [CODE_W-1:0] keyCode,
  output logic              toneOn
);

  localparam int SETTLE_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam int TIMER_W  = $clog2(DEBOUNCE_FRAMES + 1);
  localparam logic [SETTLE_W-1:0] SLOT_LAST = SETTLE_W'(SETTLE_CYCLES - 1);
  localparam logic [TIMER_W-1:0]  TIMER_RELOAD = TIMER_W'(DEBOUNCE_FRAMES);

  // Sense synchronizer
  logic [SYNC_STAGES-1:0] senseSync;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (rst) senseSync <= '0;
        else     senseSync <= senseIn;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (rst) senseSync <= '0;
        else     senseSync <= {senseSync[SYNC_STAGES-2:0], senseIn};
      end
    end
  endgenerate

  // Slot counter: select value settles before sampling
  logic [SETTLE_W-1:0] slotCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      slotCnt <= '0;
    end else if (cmd.scanStart || cmd.stepSel) begin
      slotCnt <= '0;
    end else if (slotCnt != SLOT_LAST) begin
      slotCnt <= slotCnt + SETTLE_W'(1);
    end
  end

  // Select value and captured code
  logic [CODE_W-1:0] selReg;
  logic [CODE_W-1:0] codeReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      selReg  <= '0;
      codeReg <= '0;
    end else begin
      if (cmd.stepSel)   selReg  <= selReg - CODE_W'(1);
      if (cmd.latchCode) codeReg <= selReg;
    end
  end

  // Frame-stepped debounce timer
  logic [TIMER_W-1:0] frameTimer;

  always_ff @(posedge clk) begin
    if (rst) begin
      frameTimer <= '0;
    end else if (cmd.loadTimer) begin
      frameTimer <= TIMER_RELOAD;
    end else if (frameTick && (frameTimer != '0)) begin
      frameTimer <= frameTimer - TIMER_W'(1);
    end
  end

  assign stat.slotDone  = (slotCnt == SLOT_LAST);
  assign stat.keyDown   = senseSync[SYNC_STAGES-1];
  assign stat.timerIdle = (frameTimer == '0);

  assign selOut  = selReg;
  assign keyCode = codeReg;
  assign toneOn  = (frameTimer != '0);

endmodule

// File: rtl/hexpad_ctrl.sv
module hexpad_ctrl
  import hexpad_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    scanReq,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    keyValid
);

  scanState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    cmd       = '0;
    unique case (state)
      ST_IDLE: begin
        if (scanReq) begin
          cmd.scanStart = 1'b1;
          stateNext     = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (stat.slotDone) begin
          if (stat.keyDown) begin
            cmd.latchCode = 1'b1;
            cmd.loadTimer = 1'b1;
            stateNext     = ST_PRESS_WAIT;
          end else begin
            cmd.stepSel = 1'b1;
          end
        end
      end
      ST_PRESS_WAIT: begin
        if (stat.timerIdle) stateNext = ST_HOLD_WAIT;
      end
      ST_HOLD_WAIT: begin
        // reload on every cycle, including the one that sees release
        cmd.loadTimer = 1'b1;
        if (!stat.keyDown) stateNext = ST_QUIET_WAIT;
      end
      ST_QUIET_WAIT: begin
        if (stat.timerIdle) stateNext = ST_REPORT;
      end
      ST_REPORT: begin
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign keyValid = (state == ST_REPORT);

endmodule

// File: rtl/hexpad_scanner.sv
module hexpad_scanner
  import hexpad_pkg::*;
#(
  parameter int CODE_W          = 4,
  parameter int SETTLE_CYCLES   = 4,
  parameter int DEBOUNCE_FRAMES = 4,
  parameter int SYNC_STAGES     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scanReq,
  input  logic              frameTick,
  input  logic              senseIn,
  output logic [CODE_W-1:0] selOut,
  output logic [CODE_W-1:0] keyCode,
  output logic              keyValid,
  output logic              toneOn
);

  dpCmd_t  dpCmd;
  dpStat_t dpStat;

  hexpad_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .scanReq  (scanReq),
    .stat     (dpStat),
    .cmd      (dpCmd),
    .keyValid (keyValid)
  );

  hexpad_dp #(
    .CODE_W          (CODE_W),
    .SETTLE_CYCLES   (SETTLE_CYCLES),
    .DEBOUNCE_FRAMES (DEBOUNCE_FRAMES),
    .SYNC_STAGES     (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .frameTick (frameTick),
    .senseIn   (senseIn),
    .cmd       (dpCmd),
    .stat      (dpStat),
    .selOut    (selOut),
    .keyCode   (keyCode),
    .toneOn    (toneOn)
  );

endmodule

// File: rtl/hexpad_scanner_chk.sv
module hexpad_scanner_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              frameTick,
  input logic [CODE_W-1:0] selOut,
  input logic [CODE_W-1:0] keyCode,
  input logic              keyValid,
  input logic              toneOn
);

  // R3: select only ever moves one code downward
  a_r3_descending_step: assert property (@(posedge clk) disable iff (rst)
    (selOut != $past(selOut)) |-> (selOut == ($past(selOut) - CODE_W'(1))));

  // R4: whenever the timer starts, the code matches the select value
  a_r4_code_matches_select: assert property (@(posedge clk) disable iff (rst)
    $rose(toneOn) |-> (keyCode == selOut));

  // R7: a report only appears once the timer has run down
  a_r7_report_after_quiet: assert property (@(posedge clk) disable iff (rst)
    keyValid |-> !toneOn);

  // R8: the timer cannot reach zero without a frame tick
  a_r8_no_tick_no_expiry: assert property (@(posedge clk) disable iff (rst)
    (toneOn && !frameTick) |=> toneOn);

  // R10: the report strobe lasts a single cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    keyValid |=> !keyValid);

endmodule

bind hexpad_scanner hexpad_scanner_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .frameTick (frameTick),
  .selOut    (selOut),
  .keyCode   (keyCode),
  .keyValid  (keyValid),
  .toneOn    (toneOn)
);

// File: tb/hexpad_scanner_tb.sv
`timescale 1ns/1ps
module hexpad_scanner_tb;

  localparam int CODE_W = 4;
  localparam int SETTLE = 4;
  localparam int DEB    = 4;
  localparam int NVEC   = 6;
  // {key[11:8], extra hold ticks[7:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    12'h0_00, 12'h9_02, 12'h9_00, 12'hF_01, 12'h3_03, 12'hA_05
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scanReq = 1'b0;
  logic frameTick = 1'b0;
  logic keyHeld = 1'b0;
  logic [CODE_W-1:0] pressKey = '0;
  logic senseIn;
  logic [CODE_W-1:0] selOut, keyCode;
  logic keyValid, toneOn;

  int checks = 0;
  int fails = 0;
  int validCount = 0;
  logic prevValid = 1'b0;
  bit finished = 1'b0;

  assign senseIn = keyHeld && (selOut == pressKey);

  always #4 clk = ~clk;

  hexpad_scanner #(
    .CODE_W(CODE_W), .SETTLE_CYCLES(SETTLE), .DEBOUNCE_FRAMES(DEB), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst(rst), .scanReq(scanReq), .frameTick(frameTick), .senseIn(senseIn),
    .selOut(selOut), .keyCode(keyCode), .keyValid(keyValid), .toneOn(toneOn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R10: strobe width observed at every falling edge
  always @(negedge clk) begin
    if (keyValid) begin
      validCount++;
      check(!prevValid, "R10 strobe width", 2, 1);
    end
    prevValid = keyValid;
  end

  task automatic tick();
    @(negedge clk) frameTick = 1'b1;
    @(negedge clk) frameTick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic runKey(input logic [CODE_W-1:0] key, input bit doReq, input int holdTicks);
    int startCount;
    bit seen;
    pressKey = key;
    keyHeld = 1'b1;
    startCount = validCount;
    if (doReq) begin
      @(negedge clk) scanReq = 1'b1;
      @(negedge clk) scanReq = 1'b0;
    end
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (toneOn) begin seen = 1'b1; break; end
    end
    check(seen, "R4 detection", int'(seen), 1);
    check(keyCode == key, "R4 latched code", int'(keyCode), int'(key));
    check(selOut == key, "R4 select stops on key", int'(selOut), int'(key));
    repeat (30) @(negedge clk);
    check(toneOn, "R8 timer holds without tick", int'(toneOn), 1);
    check(toneOn, "R9 tone while timer runs", int'(toneOn), 1);
    repeat (DEB) tick();
    check(toneOn, "R6 reload while held", int'(toneOn), 1);
    for (int i = 0; i < holdTicks; i++) tick();
    check(validCount == startCount, "R6 no report while held", validCount - startCount, 0);
    keyHeld = 1'b0;
    repeat (4) @(negedge clk);
    check(toneOn, "R5 timer reloaded on release", int'(toneOn), 1);
    for (int i = 0; i < DEB - 1; i++) tick();
    check(validCount == startCount, "R7 no early report", validCount - startCount, 0);
    check(toneOn, "R9 tone before last tick", int'(toneOn), 1);
    tick();
    check(validCount == startCount + 1, "R7 report after last tick", validCount - startCount, 1);
    check(keyCode == key, "R10 code held", int'(keyCode), int'(key));
    check(!toneOn, "R9 tone off at zero", int'(toneOn), 0);
    repeat (5) @(negedge clk);
    check(validCount == startCount + 1, "R10 single report", validCount - startCount, 1);
  endtask

  initial begin
    int lastChange;
    int changes;
    logic [CODE_W-1:0] prevSel;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(selOut == 0, "R1 select reset", int'(selOut), 0);
    check(keyCode == 0, "R1 code reset", int'(keyCode), 0);
    check(!keyValid, "R1 valid reset", int'(keyValid), 0);
    check(!toneOn, "R1 tone reset", int'(toneOn), 0);

    // R2: held key without a request
    pressKey = 4'h0;
    keyHeld = 1'b1;
    repeat (40) @(negedge clk);
    check(!toneOn, "R2 no tone without request", int'(toneOn), 0);
    check(validCount == 0, "R2 no report without request", validCount, 0);
    check(selOut == 0, "R2 select idle", int'(selOut), 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) runKey(VEC[v][11:8], 1'b1, int'(VEC[v][7:0]));

    // R3: observe the scan order with no key pressed
    keyHeld = 1'b0;
    @(negedge clk) scanReq = 1'b1;
    @(negedge clk) scanReq = 1'b0;
    prevSel = selOut;
    lastChange = 0;
    changes = 0;
    for (int c = 1; c <= 48; c++) begin
      @(negedge clk);
      if (selOut != prevSel) begin
        check(selOut == prevSel - CODE_W'(1), "R3 descending order",
              int'(selOut), int'(prevSel - CODE_W'(1)));
        if (changes > 0)
          check(c - lastChange == SETTLE, "R3 slot length", c - lastChange, SETTLE);
        changes++;
        lastChange = c;
        prevSel = selOut;
      end
    end
    check(changes >= 10, "R3 scanning progresses", changes, 11);
    runKey(4'h7, 1'b0, 1);

    // R10: no new scan without a request
    pressKey = selOut;
    keyHeld = 1'b1;
    repeat (100) @(negedge clk);
    check(!toneOn, "R10 no rescan without request", int'(toneOn), 0);
    keyHeld = 1'b0;

    // R8: ticks at zero leave the timer at zero
    repeat (3) tick();
    check(!toneOn, "R8 tick at zero ignored", int'(toneOn), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule